// File: doc/BRIEF.md
# Segmented Memory Protection Unit

This block sits beside a small processor's memory bus and judges every access against four permission segments. A fixed 512-byte information window forms segment 0 just below the protected area. The protected area itself is cut into segments 1, 2 and 3 by two programmable boundaries. Each segment carries its own read, write and execute enable. An access whose type is not enabled in the segment it lands in is refused in the same cycle, so a blocked write never reaches memory. Peripheral registers, SRAM, the interrupt vectors and any other address outside the window and the protected area are never checked.

Supervisor software reprograms the boundaries and permissions each time it hands the processor to a task or takes it back. Two extra lower-bound registers, one for data and one for instruction fetches, trap stray accesses that fall below the running task's own region, while still inside checked memory. When a violation occurs, the block records the address and the access type of the first fault in status registers and raises a sticky interrupt. Software clears that interrupt by writing 1.

Top module: `segment_guard`

## Requirements
- R1: After reset, fault_irq is 0, the control register reads 0, both boundaries read PROT_BASE (0x04400), the permission register reads 0 and the fault status reads 0.
- R2: In the protected area [0x04400, 0x14000), an address at or above boundary 2 is in segment 3. Otherwise, an address at or above boundary 1 is in segment 2, and any other address is in segment 1. This order holds even when boundary 1 is above boundary 2.
- R3: Segment 0 is the fixed window [0x04200, 0x04400) and uses the segment 0 permission bits whatever the boundaries hold.
- R4: The permission register (select 3) holds read, write and execute enables for segment i at bits 3i, 3i+1 and 3i+2. cpu_kind 0 is a read, 1 is a write, 2 is a fetch, and 3 is treated as a read. An access faults when the enable for its kind is clear in its segment.
- R5: Addresses below 0x04200 or at or above 0x14000 never raise cpu_err, whatever the permissions and lower bounds hold.
- R6: cpu_err is combinational, valid in the same cycle as the access, and is 0 whenever cpu_valid is 0.
- R7: The boundary registers (select 1 and 2) keep only 1 KB aligned addresses: the low 10 written bits are dropped and read back as 0.
- R8: With control bit 1 set, a checked read or write below the data lower bound (select 4) faults, and a checked fetch below the code lower bound (select 5) faults, even when the segment permits the access. Both lower bounds keep every address bit. With control bit 1 clear, the lower bounds have no effect.
- R9: The first fault latches its address (select 6) and kind (status bits 2:1), and sets status bit 0 and fault_irq on the next clock edge. Later faults do not overwrite the record while it is pending.
- R10: Writing 1 to status bit 0 (select 7) clears the pending fault and fault_irq, and writing 0 leaves them set. A fault in the same cycle as a clear is captured as a new record.
- R11: A register read with reg_re delivers the value of the selected register on reg_rdata after the next clock edge. Select 0 is control, 1 and 2 are boundaries, 3 is permissions, 4 and 5 are the lower bounds, 6 is the fault address and 7 is the fault status.
- R12: With control bit 0 clear, no access faults, including lower-bound violations.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_valid | input | 1 | Bus access present this cycle |
| cpu_addr | input | ADDR_W | Access address |
| cpu_kind | input | 2 | Access type: 0 read, 1 write, 2 fetch, 3 read |
| cpu_err | output | 1 | Access refused (combinational) |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe |
| reg_sel | input | 3 | Register select |
| reg_wdata | input | REG_W | Register write data |
| reg_rdata | output | REG_W | Register read data, one cycle after reg_re |
| fault_irq | output | 1 | Sticky fault interrupt |

## Verification
cpu_err is sampled in the cycle its access is driven, a quarter period after the following rising edge, while the inputs are still held. Register read data and fault_irq come from registers, so they are due after the first rising edge that follows the strobe or the faulting access. The driver stamps each expected item with the cycle in which it is due. The monitor compares an item only in that cycle, so a result that comes one cycle early or late is reported.

// File: rtl/sg_pkg.sv
package sg_pkg;
  localparam int NUM_SEG   = 4;
  localparam int PERM_BITS = 3;
  localparam int SEL_W     = 3;

  typedef enum logic [1:0] {
    ACC_RD  = 2'd0,
    ACC_WR  = 2'd1,
    ACC_EX  = 2'd2,
    ACC_RSV = 2'd3
  } acc_e;

  typedef enum logic [SEL_W-1:0] {
    RS_CTRL  = 3'd0,
    RS_BND1  = 3'd1,
    RS_BND2  = 3'd2,
    RS_PERM  = 3'd3,
    RS_DLO   = 3'd4,
    RS_CLO   = 3'd5,
    RS_FADDR = 3'd6,
    RS_FSTAT = 3'd7
  } rsel_e;

  // exec is the msb of each 3-bit group, read the lsb
  typedef struct packed {
    logic x;
    logic w;
    logic r;
  } perm_t;
endpackage

// File: rtl/sg_window_check.sv
module sg_window_check
  import sg_pkg::*;
#(
  parameter int ADDR_W    = 20,
  parameter int GRAN_W    = 10,
  parameter int INFO_SIZE = 512,
  parameter int PROT_BASE = 'h04400,
  parameter int PROT_TOP  = 'h14000
) (
  input  logic [ADDR_W-1:0]        addr,
  input  logic [1:0]               kind,
  input  logic                     chk_en,
  input  logic                     lb_en,
  input  logic [ADDR_W-GRAN_W-1:0] bnd1,
  input  logic [ADDR_W-GRAN_W-1:0] bnd2,
  input  perm_t [NUM_SEG-1:0]      perm,
  input  logic [ADDR_W-1:0]        dlo,
  input  logic [ADDR_W-1:0]        clo,
  output logic                     viol
);
  localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(PROT_BASE);
  localparam logic [ADDR_W-1:0] TOP_A  = ADDR_W'(PROT_TOP);
  localparam logic [ADDR_W-1:0] INFO_A = ADDR_W'(PROT_BASE - INFO_SIZE);

  logic [ADDR_W-1:0]  b1_a, b2_a;
  logic               in_info, in_main, checked, above2, above1;
  logic [NUM_SEG-1:0] seg_hit, seg_ok;
  logic               perm_ok, lb_bad;

  assign b1_a    = {bnd1, {GRAN_W{1'b0}}};
  assign b2_a    = {bnd2, {GRAN_W{1'b0}}};
  assign in_info = (addr >= INFO_A) && (addr < BASE_A);
  assign in_main = (addr >= BASE_A) && (addr < TOP_A);
  assign checked = in_info || in_main;
  assign above2  = addr >= b2_a;
  assign above1  = addr >= b1_a;

  assign seg_hit[0] = in_info;
  assign seg_hit[1] = in_main && !above2 && !above1;
  assign seg_hit[2] = in_main && !above2 && above1;
  assign seg_hit[3] = in_main && above2;

  for (genvar g = 0; g < NUM_SEG; g++) begin : g_seg
    always_comb begin
      unique case (kind)
        ACC_WR:  seg_ok[g] = perm[g].w;
        ACC_EX:  seg_ok[g] = perm[g].x;
        default: seg_ok[g] = perm[g].r;
      endcase
    end
  end

  assign perm_ok = |(seg_hit & seg_ok);
  assign lb_bad  = lb_en && ((kind == ACC_EX) ? (addr < clo) : (addr < dlo));
  assign viol    = chk_en && checked && (!perm_ok || lb_bad);

  // R2 R3: an address lands in at most one segment
  always_comb begin
    a_r2_one_segment: assert ($onehot0(seg_hit));
  end
endmodule

// File: rtl/sg_fault_log.sv
module sg_fault_log #(
  parameter int ADDR_W = 20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hit,
  input  logic [ADDR_W-1:0] hit_addr,
  input  logic [1:0]        hit_kind,
  input  logic              clr,
  output logic              pending,
  output logic [ADDR_W-1:0] addr_q,
  output logic [1:0]        kind_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      pending <= 1'b0;
      addr_q  <= '0;
      kind_q  <= '0;
    end else if (hit && (!pending || clr)) begin
      pending <= 1'b1;
      addr_q  <= hit_addr;
      kind_q  <= hit_kind;
    end else if (clr) begin
      pending <= 1'b0;
    end
  end

  a_r9_sticky: assert property (@(posedge clk) disable iff (rst)
    pending && !clr |=> pending);
  a_r9_keep_first: assert property (@(posedge clk) disable iff (rst)
    pending && !clr |=> $stable(addr_q) && $stable(kind_q));
  a_r10_clear: assert property (@(posedge clk) disable iff (rst)
    clr && !hit |=> !pending);
  a_r9_capture: assert property (@(posedge clk) disable iff (rst)
    hit && !pending |=> pending && addr_q == $past(hit_addr));
endmodule

// File: rtl/sg_regfile.sv
module sg_regfile
  import sg_pkg::*;
#(
  parameter int ADDR_W    = 20,
  parameter int REG_W     = 32,
  parameter int GRAN_W    = 10,
  parameter int PROT_BASE = 'h04400
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     reg_we,
  input  logic                     reg_re,
  input  logic [SEL_W-1:0]         reg_sel,
  input  logic [REG_W-1:0]         reg_wdata,
  output logic [REG_W-1:0]         reg_rdata,
  input  logic                     flt_pending,
  input  logic [ADDR_W-1:0]        flt_addr,
  input  logic [1:0]               flt_kind,
  output logic                     flt_clr,
  output logic                     chk_en,
  output logic                     lb_en,
  output logic [ADDR_W-GRAN_W-1:0] bnd1,
  output logic [ADDR_W-GRAN_W-1:0] bnd2,
  output perm_t [NUM_SEG-1:0]      perm,
  output logic [ADDR_W-1:0]        dlo,
  output logic [ADDR_W-1:0]        clo
);
  localparam int BW   = ADDR_W - GRAN_W;
  localparam int PW   = NUM_SEG * PERM_BITS;
  localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(PROT_BASE);

  logic unused_wdata_hi;
  assign unused_wdata_hi = ^reg_wdata[REG_W-1:ADDR_W];

  assign flt_clr = reg_we && (reg_sel == RS_FSTAT) && reg_wdata[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      chk_en <= 1'b0;
      lb_en  <= 1'b0;
      bnd1   <= BASE_A[ADDR_W-1:GRAN_W];
      bnd2   <= BASE_A[ADDR_W-1:GRAN_W];
      perm   <= '0;
      dlo    <= '0;
      clo    <= '0;
    end else if (reg_we) begin
      case (reg_sel)
        RS_CTRL: begin
          chk_en <= reg_wdata[0];
          lb_en  <= reg_wdata[1];
        end
        RS_BND1: bnd1 <= reg_wdata[ADDR_W-1:GRAN_W];
        RS_BND2: bnd2 <= reg_wdata[ADDR_W-1:GRAN_W];
        RS_PERM: perm <= reg_wdata[PW-1:0];
        RS_DLO:  dlo  <= reg_wdata[ADDR_W-1:0];
        RS_CLO:  clo  <= reg_wdata[ADDR_W-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else if (reg_re) begin
      case (reg_sel)
        RS_CTRL:  reg_rdata <= REG_W'({lb_en, chk_en});
        RS_BND1:  reg_rdata <= REG_W'({bnd1, {GRAN_W{1'b0}}});
        RS_BND2:  reg_rdata <= REG_W'({bnd2, {GRAN_W{1'b0}}});
        RS_PERM:  reg_rdata <= REG_W'(perm);
        RS_DLO:   reg_rdata <= REG_W'(dlo);
        RS_CLO:   reg_rdata <= REG_W'(clo);
        RS_FADDR: reg_rdata <= REG_W'(flt_addr);
        default:  reg_rdata <= REG_W'({flt_kind, flt_pending});
      endcase
    end
  end

  a_r7_bound_aligned: assert property (@(posedge clk) disable iff (rst)
    reg_re && (reg_sel == RS_BND1 || reg_sel == RS_BND2)
    |=> reg_rdata[GRAN_W-1:0] == '0);
  a_r11_read_hold: assert property (@(posedge clk) disable iff (rst)
    !reg_re |=> $stable(reg_rdata));
endmodule

// File: rtl/segment_guard.sv
module segment_guard
  import sg_pkg::*;
#(
  parameter int ADDR_W    = 20,
  parameter int REG_W     = 32,
  parameter int GRAN_W    = 10,
  parameter int INFO_SIZE = 512,
  parameter int PROT_BASE = 'h04400,
  parameter int PROT_TOP  = 'h14000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_valid,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [1:0]        cpu_kind,
  output logic              cpu_err,
  input  logic              reg_we,
  input  logic              reg_re,
  input  logic [2:0]        reg_sel,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  output logic              fault_irq
);
  localparam int BW = ADDR_W - GRAN_W;
  localparam logic [ADDR_W-1:0] LOW_EDGE  = ADDR_W'(PROT_BASE - INFO_SIZE);
  localparam logic [ADDR_W-1:0] HIGH_EDGE = ADDR_W'(PROT_TOP);

  logic                chk_en, lb_en, viol, flt_clr, flt_pending;
  logic [BW-1:0]       bnd1, bnd2;
  perm_t [NUM_SEG-1:0] perm;
  logic [ADDR_W-1:0]   dlo, clo, flt_addr;
  logic [1:0]          flt_kind;

  sg_regfile #(
    .ADDR_W(ADDR_W), .REG_W(REG_W), .GRAN_W(GRAN_W), .PROT_BASE(PROT_BASE)
  ) u_regs (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_re(reg_re),
    .reg_sel(reg_sel), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .flt_pending(flt_pending), .flt_addr(flt_addr), .flt_kind(flt_kind),
    .flt_clr(flt_clr), .chk_en(chk_en), .lb_en(lb_en), .bnd1(bnd1),
    .bnd2(bnd2), .perm(perm), .dlo(dlo), .clo(clo)
  );

  sg_window_check #(
    .ADDR_W(ADDR_W), .GRAN_W(GRAN_W), .INFO_SIZE(INFO_SIZE),
    .PROT_BASE(PROT_BASE), .PROT_TOP(PROT_TOP)
  ) u_check (
    .addr(cpu_addr), .kind(cpu_kind), .chk_en(chk_en), .lb_en(lb_en),
    .bnd1(bnd1), .bnd2(bnd2), .perm(perm), .dlo(dlo), .clo(clo),
    .viol(viol)
  );

  assign cpu_err = cpu_valid && viol;

  sg_fault_log #(.ADDR_W(ADDR_W)) u_log (
    .clk(clk), .rst(rst), .hit(cpu_err), .hit_addr(cpu_addr),
    .hit_kind(cpu_kind), .clr(flt_clr), .pending(flt_pending),
    .addr_q(flt_addr), .kind_q(flt_kind)
  );

  assign fault_irq = flt_pending;

  a_r6_err_needs_valid: assert property (@(posedge clk) disable iff (rst)
    !cpu_valid |-> !cpu_err);
  a_r5_exempt_quiet: assert property (@(posedge clk) disable iff (rst)
    (cpu_addr < LOW_EDGE || cpu_addr >= HIGH_EDGE) |-> !cpu_err);
  a_r12_off_quiet: assert property (@(posedge clk) disable iff (rst)
    !chk_en |-> !cpu_err);
  a_r9_irq_on_fault: assert property (@(posedge clk) disable iff (rst)
    cpu_err |=> fault_irq);
endmodule

// File: tb/tb_segment_guard.sv
module tb_segment_guard;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic        clk = 1'b0;
  logic        rst;
  logic        cpu_valid, reg_we, reg_re;
  logic [19:0] cpu_addr;
  logic [1:0]  cpu_kind;
  logic        cpu_err, fault_irq;
  logic [2:0]  reg_sel;
  logic [31:0] reg_wdata, reg_rdata;

  segment_guard dut (
    .clk(clk), .rst(rst), .cpu_valid(cpu_valid), .cpu_addr(cpu_addr),
    .cpu_kind(cpu_kind), .cpu_err(cpu_err), .reg_we(reg_we),
    .reg_re(reg_re), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .fault_irq(fault_irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct {
    int          due;
    int          what;   // 0 cpu_err, 1 reg_rdata, 2 fault_irq
    logic [31:0] exp;
    string       tag;
  } item_t;

  item_t sbq[$];
  int cyc = 0;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  // monitor: samples a quarter period after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      #(CLK_PERIOD/4);
      while (sbq.size() > 0 && sbq[0].due <= cyc) begin
        item_t it;
        logic [31:0] act;
        it = sbq.pop_front();
        case (it.what)
          0:       act = {31'd0, cpu_err};
          1:       act = reg_rdata;
          default: act = {31'd0, fault_irq};
        endcase
        checks++;
        if (act !== it.exp) begin
          errors++;
          $display("FAIL %s: actual %h expected %h (cycle %0d)", it.tag, act, it.exp, cyc);
        end
      end
    end
  end

  task automatic drive(input logic v, input logic [19:0] a, input logic [1:0] k,
                       input logic we, input logic re, input logic [2:0] s,
                       input logic [31:0] d);
    @(negedge clk);
    cpu_valid = v; cpu_addr = a; cpu_kind = k;
    reg_we = we; reg_re = re; reg_sel = s; reg_wdata = d;
  endtask

  task automatic expect_at_next(input int what, input logic [31:0] exp, input string tag);
    item_t it;
    it.due = cyc + 1; it.what = what; it.exp = exp; it.tag = tag;
    sbq.push_back(it);
  endtask

  task automatic acc(input logic [19:0] a, input logic [1:0] k, input logic e, input string tag);
    drive(1'b1, a, k, 1'b0, 1'b0, 3'd0, 32'd0);
    expect_at_next(0, {31'd0, e}, tag);
  endtask

  task automatic wreg(input logic [2:0] s, input logic [31:0] d);
    drive(1'b0, 20'd0, 2'd0, 1'b1, 1'b0, s, d);
  endtask

  task automatic rreg(input logic [2:0] s, input logic [31:0] e, input string tag);
    drive(1'b0, 20'd0, 2'd0, 1'b0, 1'b1, s, 32'd0);
    expect_at_next(1, e, tag);
  endtask

  task automatic irq(input logic e, input string tag);
    drive(1'b0, 20'd0, 2'd0, 1'b0, 1'b0, 3'd0, 32'd0);
    expect_at_next(2, {31'd0, e}, tag);
  endtask

  task automatic idle();
    drive(1'b0, 20'd0, 2'd0, 1'b0, 1'b0, 3'd0, 32'd0);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    rst = 1'b1;
    cpu_valid = 0; cpu_addr = 0; cpu_kind = 0;
    reg_we = 0; reg_re = 0; reg_sel = 0; reg_wdata = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    irq(1'b0, "R1 irq");
    rreg(3'd0, 32'h0, "R1 ctrl");
    rreg(3'd1, 32'h04400, "R1 bound1");
    rreg(3'd2, 32'h04400, "R1 bound2");
    rreg(3'd3, 32'h0, "R1 perm");
    rreg(3'd7, 32'h0, "R1 status");
    // R12 checking off: no faults
    acc(20'h05000, 2'd0, 1'b0, "R12 off read");

    // R7 alignment
    wreg(3'd1, 32'h08123);
    wreg(3'd2, 32'h0C3FF);
    rreg(3'd1, 32'h08000, "R7 bound1");
    rreg(3'd2, 32'h0C000, "R7 bound2");
    // R4 seg1 exec-only, seg2 read-write, seg0/seg3 none
    wreg(3'd3, 32'h0E0);
    rreg(3'd3, 32'h0E0, "R11 perm readback");
    wreg(3'd0, 32'h1);

    acc(20'h05000, 2'd2, 1'b0, "R4 seg1 exec allowed");
    acc(20'h05000, 2'd0, 1'b1, "R4 seg1 read refused");
    acc(20'h07FFF, 2'd1, 1'b1, "R2 seg1 top write refused");
    acc(20'h08000, 2'd0, 1'b0, "R2 seg2 base read");
    acc(20'h0BFFE, 2'd1, 1'b0, "R4 seg2 write");
    acc(20'h08000, 2'd2, 1'b1, "R4 seg2 exec refused");
    acc(20'h0C000, 2'd1, 1'b1, "R2 seg3 base write refused");
    acc(20'h13FFF, 2'd0, 1'b1, "R2 seg3 top read refused");
    acc(20'h0C000, 2'd3, 1'b1, "R4 kind3 as read");
    acc(20'h04200, 2'd0, 1'b1, "R3 info low");
    acc(20'h043FF, 2'd1, 1'b1, "R3 info high");
    acc(20'h041FF, 2'd1, 1'b0, "R5 below info");
    acc(20'h14000, 2'd2, 1'b0, "R5 above top");
    acc(20'h00100, 2'd0, 1'b0, "R5 low periph");
    drive(1'b0, 20'h0C000, 2'd1, 1'b0, 1'b0, 3'd0, 32'd0);
    expect_at_next(0, 32'd0, "R6 no valid");

    // R9 first fault kept
    irq(1'b1, "R9 irq set");
    rreg(3'd6, 32'h05000, "R9 first address");
    rreg(3'd7, 32'h1, "R9 status kind read");
    // R10
    wreg(3'd7, 32'h0);
    irq(1'b1, "R10 write zero keeps");
    wreg(3'd7, 32'h1);
    irq(1'b0, "R10 cleared");
    rreg(3'd7, 32'h0, "R10 status clear");
    acc(20'h0C010, 2'd1, 1'b1, "R9 write fault");
    rreg(3'd6, 32'h0C010, "R9 new address");
    rreg(3'd7, 32'h3, "R9 write kind");
    // R10 fault in same cycle as clear
    drive(1'b1, 20'h13000, 2'd2, 1'b1, 1'b0, 3'd7, 32'h1);
    expect_at_next(0, 32'd1, "R10 concurrent fault err");
    irq(1'b1, "R10 concurrent capture");
    rreg(3'd6, 32'h13000, "R10 concurrent address");
    rreg(3'd7, 32'h5, "R10 concurrent kind");
    wreg(3'd7, 32'h1);

    // R8 lower bounds
    wreg(3'd4, 32'h09000);
    wreg(3'd5, 32'h06000);
    rreg(3'd4, 32'h09000, "R8 dlo readback");
    acc(20'h08800, 2'd0, 1'b0, "R8 lb disabled");
    wreg(3'd0, 32'h3);
    acc(20'h08800, 2'd0, 1'b1, "R8 read below data bound");
    acc(20'h08FFF, 2'd1, 1'b1, "R8 write below data bound");
    acc(20'h09000, 2'd0, 1'b0, "R8 read at data bound");
    acc(20'h05FFE, 2'd2, 1'b1, "R8 fetch below code bound");
    acc(20'h06000, 2'd2, 1'b0, "R8 fetch at code bound");
    acc(20'h00100, 2'd0, 1'b0, "R5 exempt below bound");
    wreg(3'd0, 32'h2);
    acc(20'h08800, 2'd0, 1'b0, "R12 off with lb");
    acc(20'h0C000, 2'd1, 1'b0, "R12 off seg3");
    rreg(3'd0, 32'h2, "R11 ctrl readback");

    // R2 crossed boundaries
    wreg(3'd0, 32'h1);
    wreg(3'd1, 32'h0D000);
    wreg(3'd2, 32'h0A000);
    acc(20'h0B000, 2'd0, 1'b1, "R2 crossed seg3");
    acc(20'h09000, 2'd2, 1'b0, "R2 crossed seg1 exec");
    acc(20'h09000, 2'd0, 1'b1, "R2 crossed seg1 read");
    idle();

    wait (sbq.size() == 0);
    idle();
    done = 1;
    summary();
    $finish;
  end
endmodule